// File: doc/BRIEF.md
# Processor Status Word Register

This block holds the eight-bit status word of a small processor core. It keeps the arithmetic result flags written by the ALU, a single transfer bit used to move one bit between a general register and the status word, and the global interrupt enable. The status word can be read and written as a whole over an I/O bus port. It also responds to interrupt-entry and interrupt-return strobes and to explicit enable-set and enable-clear commands.

The block gates the interrupt request. Pending lines are ANDed with their individual enables, and the result is forwarded only while the global enable bit is set. A bit-store strobe copies one selected bit of a supplied register byte into the transfer bit. A combinational bit-load output returns that byte with the selected bit replaced by the transfer bit. The ALU datapath, instruction decode and vector selection live elsewhere.

Top module: `proc_status_reg`

## Requirements
- R1: After reset all eight status bits are 0. Bit positions: 7 global enable, 6 transfer bit, 5 half carry, 4 sign, 3 overflow, 2 negative, 1 zero, 0 carry.
- R2: An I/O write with `io_addr` equal to `IO_ADDR` (default 6'h3F) loads all eight bits from `io_wdata`. `io_rdata` shows the status word when the address matches and 0 when it does not.
- R3: `irq_req` equals the global enable ANDed with the OR over all bits of `irq_pending & irq_enable`. It is combinational.
- R4: `irq_accept` clears the global enable at the next edge, so `irq_req` is low from the next cycle.
- R5: `irq_return` sets the global enable at the next edge.
- R6: `gie_set` sets the global enable and `gie_clr` clears it. When both are high, clear wins.
- R7: The global enable follows this priority: accept, then return, then clear, then set, then I/O write. An I/O write overrides the ALU update and the bit store for all other bits.
- R8: With `alu_we` high, only the half carry, overflow, negative, zero and carry bits selected by `alu_mask` take their values from `alu_flags`, at the same positions. Mask bits 7, 6 and 4 are ignored.
- R9: When an ALU update masks the negative or overflow bit, the sign bit becomes negative XOR overflow, using the updated values. Otherwise the ALU leaves the sign bit unchanged.
- R10: `bit_store` copies `reg_byte[bit_idx]` into the transfer bit.
- R11: `bld_byte` equals `reg_byte` with bit `bit_idx` replaced by the current transfer bit. It is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 6 | I/O bus address |
| io_we | input | 1 | I/O bus write strobe |
| io_wdata | input | 8 | I/O bus write data |
| io_rdata | output | 8 | I/O bus read data |
| alu_we | input | 1 | ALU flag update strobe |
| alu_mask | input | 8 | Per-bit update mask |
| alu_flags | input | 8 | New flag values |
| irq_accept | input | 1 | Interrupt entry strobe |
| irq_return | input | 1 | Return-from-interrupt strobe |
| gie_set | input | 1 | Force global enable to 1 |
| gie_clr | input | 1 | Force global enable to 0 |
| bit_store | input | 1 | Copy a register bit into the transfer bit |
| bit_idx | input | 3 | Selected bit index |
| reg_byte | input | 8 | Register byte for bit store and bit load |
| bld_byte | output | 8 | Register byte with selected bit replaced by transfer bit |
| irq_pending | input | NUM_IRQ | Pending interrupt lines |
| irq_enable | input | NUM_IRQ | Individual interrupt enables |
| irq_req | output | 1 | Gated interrupt request |
| status_q | output | 8 | Current status word |

## Verification
The assertions check these rules on every cycle:
- the request is masked after an accept;
- the enable clears on accept and sets on return;
- the sign bit is re-derived after ALU updates that touch negative or overflow;
- the bit store reaches the transfer bit;
- unmasked carry holds.

Only the bench scenarios can show some behaviours:
- the full same-cycle priority among accept, return, the enable commands, bus writes and ALU updates;
- the address decode of reads;
- the combinational bit-load byte across all indices.

The bench drives random mixes of all these strobes and compares the result against a reference model built from the requirements.

// File: rtl/proc_status_reg.sv
module proc_status_reg #(
  parameter int NUM_IRQ = 8,
  parameter int AW = 6,
  parameter logic [AW-1:0] IO_ADDR = 6'h3F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      io_addr,
  input  logic               io_we,
  input  logic [7:0]         io_wdata,
  output logic [7:0]         io_rdata,
  input  logic               alu_we,
  input  logic [7:0]         alu_mask,
  input  logic [7:0]         alu_flags,
  input  logic               irq_accept,
  input  logic               irq_return,
  input  logic               gie_set,
  input  logic               gie_clr,
  input  logic               bit_store,
  input  logic [2:0]         bit_idx,
  input  logic [7:0]         reg_byte,
  output logic [7:0]         bld_byte,
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic [NUM_IRQ-1:0] irq_enable,
  output logic               irq_req,
  output logic [7:0]         status_q
);
  localparam int B_I = 7, B_T = 6, B_S = 4, B_V = 3, B_N = 2;
  localparam logic [7:0] ALU_BITS = 8'b0010_1111;

  logic [7:0] sr, nxt, amask;
  logic       io_sel, io_wr;

  assign io_sel   = (io_addr == IO_ADDR);
  assign io_wr    = io_we && io_sel;
  assign io_rdata = io_sel ? sr : 8'h00;
  assign status_q = sr;
  assign amask    = alu_mask & ALU_BITS;
  assign irq_req  = sr[B_I] && |(irq_pending & irq_enable);

  always_comb begin
    bld_byte          = reg_byte;
    bld_byte[bit_idx] = sr[B_T];
  end

  always_comb begin
    nxt = sr;
    if (bit_store) nxt[B_T] = reg_byte[bit_idx];
    if (alu_we) begin
      nxt = (nxt & ~amask) | (alu_flags & amask);
      if (amask[B_N] || amask[B_V]) nxt[B_S] = nxt[B_N] ^ nxt[B_V];
    end
    if (io_wr)      nxt = io_wdata;
    if (gie_set)    nxt[B_I] = 1'b1;
    if (gie_clr)    nxt[B_I] = 1'b0;
    if (irq_return) nxt[B_I] = 1'b1;
    if (irq_accept) nxt[B_I] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sr <= 8'h00;
    else        sr <= nxt;
  end

  assert_accept_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |=> !status_q[B_I]);
  assert_req_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |=> !irq_req);
  assert_return_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && !irq_accept) |=> status_q[B_I]);
  assert_clr_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_clr && !irq_return) |=> !status_q[B_I]);
  assert_sign_derived_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we && !io_wr && (alu_mask[B_N] || alu_mask[B_V]))
      |=> (status_q[B_S] == (status_q[B_N] ^ status_q[B_V])));
  assert_unmasked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_wr && !(alu_we && alu_mask[0])) |=> $stable(status_q[0]));
  assert_bit_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_store && !io_wr) |=> (status_q[B_T] == $past(reg_byte[bit_idx])));
endmodule

// File: tb/proc_status_reg_tb.sv
`timescale 1ns/1ps
module proc_status_reg_tb;
  logic clk = 0, rst_n = 0;
  logic [5:0] io_addr = 0;
  logic io_we = 0, alu_we = 0, irq_accept = 0, irq_return = 0;
  logic gie_set = 0, gie_clr = 0, bit_store = 0;
  logic [7:0] io_wdata = 0, alu_mask = 0, alu_flags = 0, reg_byte = 0;
  logic [2:0] bit_idx = 0;
  logic [7:0] irq_pending = 0, irq_enable = 0;
  logic [7:0] io_rdata, bld_byte, status_q;
  logic irq_req;
  int checks = 0, fails = 0;
  logic [7:0] exp_sr = 0;

  always #2.5 clk = ~clk;

  proc_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_we(io_we), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .alu_we(alu_we), .alu_mask(alu_mask), .alu_flags(alu_flags),
    .irq_accept(irq_accept), .irq_return(irq_return), .gie_set(gie_set), .gie_clr(gie_clr),
    .bit_store(bit_store), .bit_idx(bit_idx), .reg_byte(reg_byte), .bld_byte(bld_byte),
    .irq_pending(irq_pending), .irq_enable(irq_enable), .irq_req(irq_req), .status_q(status_q));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [7:0] s);
    logic [7:0] n = s, m;
    m = alu_mask & 8'h2F;
    if (bit_store) n[6] = reg_byte[bit_idx];                       // R10
    if (alu_we) begin                                               // R8
      n = (n & ~m) | (alu_flags & m);
      if (m[2] || m[3]) n[4] = n[2] ^ n[3];                         // R9
    end
    if (io_we && io_addr == 6'h3F) n = io_wdata;                    // R2
    if (gie_set) n[7] = 1;                                          // R6, R7
    if (gie_clr) n[7] = 0;
    if (irq_return) n[7] = 1;                                       // R5
    if (irq_accept) n[7] = 0;                                       // R4
    return n;
  endfunction

  function automatic logic [7:0] exp_bld(input logic [7:0] s);
    logic [7:0] b = reg_byte;
    b[bit_idx] = s[6];
    return b;
  endfunction

  task automatic idle();
    io_we = 0; alu_we = 0; irq_accept = 0; irq_return = 0;
    gie_set = 0; gie_clr = 0; bit_store = 0;
  endtask

  // Call after inputs are set at a negedge: check combinational outputs, then advance one edge.
  task automatic step(input string req);
    logic [7:0] nx;
    #1;
    chk("R3", {7'd0, irq_req}, {7'd0, exp_sr[7] & |(irq_pending & irq_enable)});
    chk("R11", bld_byte, exp_bld(exp_sr));
    chk("R2", io_rdata, (io_addr == 6'h3F) ? exp_sr : 8'h00);
    nx = model(exp_sr);
    @(negedge clk);
    exp_sr = nx;
    chk(req, status_q, exp_sr);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", status_q, 8'h00);
    // R2: full-byte write then read back
    io_addr = 6'h3F; io_we = 1; io_wdata = 8'hA5; step("R2");
    idle(); io_addr = 6'h10; step("R2 no-match read");
    // R4/R5: accept and return in the same cycle, accept wins
    io_addr = 6'h3F; io_we = 1; io_wdata = 8'h80; step("R2");
    idle(); irq_pending = 8'h04; irq_enable = 8'h04;
    irq_accept = 1; irq_return = 1; step("R7 accept over return");
    idle(); step("R4 request masked");
    irq_return = 1; gie_clr = 1; step("R7 return over clear");
    idle(); gie_set = 1; gie_clr = 1; step("R6 clear wins");
    idle(); gie_set = 1; io_we = 1; io_wdata = 8'h00; step("R7 set over io write");
    // R8/R9: ALU update with mask touching sign and transfer bits
    idle(); alu_we = 1; alu_mask = 8'hFF; alu_flags = 8'h48; step("R9 sign from N^V");
    idle(); alu_we = 1; alu_mask = 8'h21; alu_flags = 8'hFF; step("R8 partial mask");
    // R10/R11 all indices
    for (int i = 0; i < 8; i++) begin
      idle(); bit_store = 1; bit_idx = i[2:0]; reg_byte = 8'h5A; step("R10 bit store");
    end
    // R7: io write beats ALU and bit store
    idle(); io_we = 1; io_wdata = 8'h3C; alu_we = 1; alu_mask = 8'hFF; alu_flags = 8'h00;
    bit_store = 1; reg_byte = 8'hFF; step("R7 io over alu");
    // random mix
    for (int k = 0; k < 3000; k++) begin
      idle();
      io_addr    = ($urandom % 4 == 0) ? 6'h3F : 6'($urandom);
      io_we      = ($urandom % 6 == 0);
      io_wdata   = 8'($urandom);
      alu_we     = ($urandom % 2 == 0);
      alu_mask   = 8'($urandom);
      alu_flags  = 8'($urandom);
      irq_accept = ($urandom % 8 == 0);
      irq_return = ($urandom % 8 == 0);
      gie_set    = ($urandom % 6 == 0);
      gie_clr    = ($urandom % 6 == 0);
      bit_store  = ($urandom % 4 == 0);
      bit_idx    = 3'($urandom);
      reg_byte   = 8'($urandom);
      irq_pending = 8'($urandom);
      irq_enable  = 8'($urandom);
      step("R7/R8/R9 random");
    end
    idle(); rst_n = 0; @(negedge clk); exp_sr = 0;
    chk("R1 reset", status_q, 8'h00);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule